// File: doc/BRIEF.md
# Multi-lane serial flash slave front-end

This block is the serial front-end of a flash-style serial slave. It runs entirely on the serial clock and is active only while the active-low chip select is low. Every transaction starts with an 8-bit opcode shifted in on IO0. The block decodes that opcode and picks how many data lanes carry the rest of the transaction: one, two or four. It makes that choice separately for the address bytes and for the data bytes. When four lanes are used, the write-protect and hold pins are reused as IO2 and IO3.

Four-lane opcodes are accepted only when the quad-enable input is 1. If one arrives while quad-enable is 0, the transaction is marked invalid and the block stays silent until chip select rises.

Received bytes and the opcode go to a command layer over a one-cycle strobe interface. Read data comes back on `tx_byte_i` and leaves through the IO pads. The block drives a separate output-enable bit for each lane.

Top module: `spi_lane_front`

## Requirements
- R1: Serial clock modes 0 and 3 both work. Input bits are sampled on the rising edge and output bits change on the falling edge. Chip select may fall while the clock is low or while it is high.
- R2: The opcode is 8 bits on IO0, MSB first, one bit per rising edge. One cycle after the 8th rising edge, `op_valid_o` is high for exactly one cycle and `opcode_o` holds the opcode.
- R3: Any opcode not named in R4 to R7 runs on a single lane. Input comes only on IO0, and output goes only on IO1: while the block drives, `io_oe_o` = 4'b0010.
- R4: Opcodes 0xBB and 0x92 carry both the address and the data on two lanes (IO1, IO0). `lanes_o` reports the width currently in use: 0 for one lane, 1 for two lanes, 2 for four lanes.
- R5: Opcode 0x3B carries the address on one lane and the data on two lanes.
- R6: With quad-enable at 1, opcodes 0xEB, 0xE7 and 0x94 carry both the address and the data on four lanes (IO3 to IO0).
- R7: With quad-enable at 1, opcodes 0x6B and 0x32 carry the address on one lane and the data on four lanes.
- R8: If quad-enable is 0 when an R6 or R7 opcode completes, `invalid_o` goes high and stays high. After that, no byte strobes are produced and `io_oe_o` stays 0 until chip select rises.
- R9: In two-lane and four-lane modes, each beat carries the next most significant bits of the byte. The highest-numbered lane carries the most significant bit of the beat. This holds in both the receive and the transmit direction.
- R10: Chip select high, or `rst_ni` low, clears at once the bit count, the phase, the strobes, `invalid_o` and all output enables. The next transaction starts again at the opcode.
- R11: The first ADDR_BYTES bytes after the opcode are address bytes and are marked with `rx_addr_o` = 1. One cycle after the rising edge that completes each byte, `rx_valid_o` is high for one cycle with that byte on `rx_byte_o`.
- R12: During the data phase with `tx_en_i` = 1, the block takes `tx_byte_i` on the falling edge that starts each byte and shifts it out at the data-phase width, with the enables set for those lanes. At all other times `io_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| qe_i | input | 1 | Quad-enable configuration bit |
| io_i | input | 4 | Pad input values, IO3 to IO0 |
| tx_en_i | input | 1 | Command layer requests output in the data phase |
| tx_byte_i | input | 8 | Byte to transmit |
| io_o | output | 4 | Pad output values |
| io_oe_o | output | 4 | Per-lane output enable |
| lanes_o | output | 2 | Current lane width code |
| invalid_o | output | 1 | Four-lane opcode rejected |
| op_valid_o | output | 1 | Opcode strobe |
| opcode_o | output | 8 | Received opcode |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_byte_o | output | 8 | Received byte |
| rx_addr_o | output | 1 | Strobed byte belongs to the address phase |

## Verification
The assertions check several properties on every clock:
- `io_oe_o` only ever takes one of the three legal lane masks, and never enables IO0 in single-lane mode.
- A rejected transaction never turns an enable on, and the rejected state cannot be left while chip select is low.
- Byte strobes fall only on byte boundaries, and the opcode strobe fires once per transaction.

Some behaviours only the bench scenarios can show:
- That each opcode maps to the right address and data widths.
- That bits are packed in the right order.
- That the first output beat lines up with the first data byte.
- That both clock modes and an abort in the middle of a byte behave as required.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_N = 4;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;
  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_DEAD} phase_e;

  function automatic logic [3:0] lane_step(lane_e w);
    case (w)
      LN_2:    return 4'd2;
      LN_4:    return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [LANE_N-1:0] lane_mask(lane_e w);
    case (w)
      LN_2:    return 4'b0011;
      LN_4:    return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction
endpackage

// File: rtl/spi_lane_decode.sv
module spi_lane_decode
  import spi_lane_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output lane_e             addr_w_o,
  output lane_e             data_w_o,
  output logic              quad_o
);
  localparam logic [7:0] OP_DO2 = 8'h3B;
  localparam logic [7:0] OP_DI2 = 8'hBB;
  localparam logic [7:0] OP_ID2 = 8'h92;
  localparam logic [7:0] OP_DO4 = 8'h6B;
  localparam logic [7:0] OP_DI4 = 8'hEB;
  localparam logic [7:0] OP_WD4 = 8'hE7;
  localparam logic [7:0] OP_ID4 = 8'h94;
  localparam logic [7:0] OP_PP4 = 8'h32;

  always_comb begin
    addr_w_o = LN_1;
    data_w_o = LN_1;
    case (op_i)
      OP_DO2:                 data_w_o = LN_2;
      OP_DI2, OP_ID2:         begin addr_w_o = LN_2; data_w_o = LN_2; end
      OP_DO4, OP_PP4:         data_w_o = LN_4;
      OP_DI4, OP_WD4, OP_ID4: begin addr_w_o = LN_4; data_w_o = LN_4; end
      default: ;
    endcase
  end

  assign quad_o = (data_w_o == LN_4);
endmodule

// File: rtl/spi_lane_rx.sv
module spi_lane_rx
  import spi_lane_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic              sclk_i,
  input  logic              sess_ni,
  input  logic              qe_i,
  input  logic [LANE_N-1:0] io_i,
  output phase_e            phase_o,
  output lane_e             width_o,
  output logic [2:0]        bit_cnt_o,
  output logic              op_valid_o,
  output logic [BYTE_W-1:0] opcode_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_addr_o
);
  localparam int ACNT_W = (ADDR_BYTES < 2) ? 1 : $clog2(ADDR_BYTES);

  phase_e             phase_q;
  lane_e              aw_q, dw_q, width;
  logic [2:0]         bit_cnt_q;
  logic [3:0]         sum;
  logic               byte_done;
  logic [BYTE_W-1:0]  sr_q, shift_nx;
  logic [ACNT_W-1:0]  addr_cnt_q;
  logic               op_valid_q, rx_valid_q, rx_addr_q;
  logic [BYTE_W-1:0]  opcode_q, rx_byte_q;
  lane_e              dec_aw, dec_dw;
  logic               dec_quad;

  always_comb begin
    case (phase_q)
      PH_ADDR: width = aw_q;
      PH_DATA: width = dw_q;
      default: width = LN_1;
    endcase
  end

  // highest lane lands in the more significant position
  always_comb begin
    case (width)
      LN_2:    shift_nx = {sr_q[BYTE_W-3:0], io_i[1:0]};
      LN_4:    shift_nx = {sr_q[BYTE_W-5:0], io_i[3:0]};
      default: shift_nx = {sr_q[BYTE_W-2:0], io_i[0]};
    endcase
  end

  assign sum       = {1'b0, bit_cnt_q} + lane_step(width);
  assign byte_done = sum[3];

  spi_lane_decode u_dec (
    .op_i     (shift_nx),
    .addr_w_o (dec_aw),
    .data_w_o (dec_dw),
    .quad_o   (dec_quad)
  );

  always_ff @(posedge sclk_i or negedge sess_ni) begin
    if (!sess_ni) begin
      phase_q    <= PH_OP;
      aw_q       <= LN_1;
      dw_q       <= LN_1;
      bit_cnt_q  <= '0;
      sr_q       <= '0;
      addr_cnt_q <= '0;
      op_valid_q <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_addr_q  <= 1'b0;
      opcode_q   <= '0;
      rx_byte_q  <= '0;
    end else begin
      op_valid_q <= 1'b0;
      rx_valid_q <= 1'b0;
      if (phase_q != PH_DEAD) begin
        sr_q      <= shift_nx;
        bit_cnt_q <= sum[2:0];
      end
      if (byte_done) begin
        case (phase_q)
          PH_OP: begin
            opcode_q   <= shift_nx;
            op_valid_q <= 1'b1;
            if (dec_quad && !qe_i) begin
              phase_q <= PH_DEAD;
            end else begin
              aw_q    <= dec_aw;
              dw_q    <= dec_dw;
              phase_q <= (ADDR_BYTES == 0) ? PH_DATA : PH_ADDR;
            end
          end
          PH_ADDR: begin
            rx_valid_q <= 1'b1;
            rx_byte_q  <= shift_nx;
            rx_addr_q  <= 1'b1;
            addr_cnt_q <= addr_cnt_q + 1'b1;
            if (int'(addr_cnt_q) == ADDR_BYTES - 1) phase_q <= PH_DATA;
          end
          PH_DATA: begin
            rx_valid_q <= 1'b1;
            rx_byte_q  <= shift_nx;
            rx_addr_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o    = phase_q;
  assign width_o    = width;
  assign bit_cnt_o  = bit_cnt_q;
  assign op_valid_o = op_valid_q;
  assign opcode_o   = opcode_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
  assign rx_addr_o  = rx_addr_q;

  AST_OP_ONCE: assert property (@(posedge sclk_i) disable iff (!sess_ni)
    op_valid_q |=> (!op_valid_q && phase_q != PH_OP)); // R2
  AST_NO_RX_IN_OP: assert property (@(posedge sclk_i) disable iff (!sess_ni)
    (phase_q == PH_OP) |-> !rx_valid_q); // R2
  AST_RX_ON_BOUNDARY: assert property (@(posedge sclk_i) disable iff (!sess_ni)
    rx_valid_q |-> (bit_cnt_q == 3'd0)); // R11
  AST_DEAD_STICKY: assert property (@(posedge sclk_i) disable iff (!sess_ni)
    (phase_q == PH_DEAD) |=> (phase_q == PH_DEAD && !rx_valid_q)); // R8
  AST_QUAD_GATED: assert property (@(posedge sclk_i) disable iff (!sess_ni)
    (op_valid_q && phase_q != PH_DEAD && dw_q == LN_4) |-> $past(qe_i)); // R8
endmodule

// File: rtl/spi_lane_tx.sv
module spi_lane_tx
  import spi_lane_pkg::*;
(
  input  logic              sclk_i,
  input  logic              sess_ni,
  input  logic              drive_i,
  input  lane_e             width_i,
  input  logic [2:0]        bit_cnt_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [LANE_N-1:0] io_o,
  output logic [LANE_N-1:0] io_oe_o
);
  logic [BYTE_W-1:0] sr_q, cur;
  logic [LANE_N-1:0] io_q, oe_q, io_nx;

  assign cur = (bit_cnt_i == 3'd0) ? tx_byte_i : sr_q;

  always_comb begin
    case (width_i)
      LN_2:    io_nx = {2'b00, cur[7:6]};
      LN_4:    io_nx = cur[7:4];
      default: io_nx = {2'b00, cur[7], 1'b0};
    endcase
  end

  always_ff @(negedge sclk_i or negedge sess_ni) begin
    if (!sess_ni) begin
      sr_q <= '0;
      io_q <= '0;
      oe_q <= '0;
    end else if (drive_i) begin
      io_q <= io_nx;
      oe_q <= lane_mask(width_i);
      sr_q <= cur << lane_step(width_i);
    end else begin
      oe_q <= '0;
    end
  end

  assign io_o    = io_q;
  assign io_oe_o = oe_q;

  AST_OE_SHAPE: assert property (@(negedge sclk_i) disable iff (!sess_ni)
    (oe_q == 4'b0000 || oe_q == 4'b0010 || oe_q == 4'b0011 || oe_q == 4'b1111)); // R3
  AST_SI_INPUT_ONLY: assert property (@(negedge sclk_i) disable iff (!sess_ni)
    (width_i == LN_1) |-> !oe_q[0]); // R3
  AST_HIZ_WHEN_IDLE: assert property (@(negedge sclk_i) disable iff (!sess_ni)
    !drive_i |=> (oe_q == 4'b0000)); // R12
endmodule

// File: rtl/spi_lane_front.sv
module spi_lane_front
  import spi_lane_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic       sclk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       qe_i,
  input  logic [3:0] io_i,
  input  logic       tx_en_i,
  input  logic [7:0] tx_byte_i,
  output logic [3:0] io_o,
  output logic [3:0] io_oe_o,
  output logic [1:0] lanes_o,
  output logic       invalid_o,
  output logic       op_valid_o,
  output logic [7:0] opcode_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_addr_o
);
  logic       sess_n;
  phase_e     phase;
  lane_e      width;
  logic [2:0] bit_cnt;
  logic       drive;

  // a session exists only while selected and out of reset
  assign sess_n = rst_ni & ~cs_ni;

  spi_lane_rx #(.ADDR_BYTES(ADDR_BYTES)) u_rx (
    .sclk_i     (sclk_i),
    .sess_ni    (sess_n),
    .qe_i       (qe_i),
    .io_i       (io_i),
    .phase_o    (phase),
    .width_o    (width),
    .bit_cnt_o  (bit_cnt),
    .op_valid_o (op_valid_o),
    .opcode_o   (opcode_o),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o),
    .rx_addr_o  (rx_addr_o)
  );

  assign drive = (phase == PH_DATA) && tx_en_i;

  spi_lane_tx u_tx (
    .sclk_i    (sclk_i),
    .sess_ni   (sess_n),
    .drive_i   (drive),
    .width_i   (width),
    .bit_cnt_i (bit_cnt),
    .tx_byte_i (tx_byte_i),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

  assign lanes_o   = 2'(width);
  assign invalid_o = (phase == PH_DEAD);

  AST_INVALID_SILENT: assert property (@(posedge sclk_i) disable iff (!sess_n)
    invalid_o |-> (io_oe_o == 4'b0000 && !rx_valid_o)); // R8
  AST_LANES_LEGAL: assert property (@(posedge sclk_i) disable iff (!sess_n)
    lanes_o != 2'd3); // R4
endmodule

// File: tb/tb_spi_lane_front.sv
module tb_spi_lane_front;
  localparam int ADDR = 3;

  logic       sclk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       qe_i = 1'b0;
  logic [3:0] io_i = 4'h0;
  logic       tx_en_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic [3:0] io_o, io_oe_o;
  logic [1:0] lanes_o;
  logic       invalid_o, op_valid_o, rx_valid_o, rx_addr_o;
  logic [7:0] opcode_o, rx_byte_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit first_beat;
  string cur_tag = "R10";
  logic [7:0] got[$];

  // reference model state
  int m_bits, m_nbytes, m_aw, m_dw;
  bit m_dead;
  logic [7:0] m_acc, m_tx;
  bit e_opv, e_rxv, e_rxa;
  logic [7:0] e_op, e_rxb;
  logic [1:0] e_lanes;
  logic [3:0] e_oe, e_io;

  always #4 sclk = ~sclk;

  spi_lane_front #(.ADDR_BYTES(ADDR)) dut (
    .sclk_i(sclk), .rst_ni(rst_ni), .cs_ni(cs_ni), .qe_i(qe_i), .io_i(io_i),
    .tx_en_i(tx_en_i), .tx_byte_i(tx_byte_i), .io_o(io_o), .io_oe_o(io_oe_o),
    .lanes_o(lanes_o), .invalid_o(invalid_o), .op_valid_o(op_valid_o),
    .opcode_o(opcode_o), .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o),
    .rx_addr_o(rx_addr_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s actual=%0h expected=%0h", req, cur_tag, what, act, exp);
    end
  endtask

  function automatic void dec(input logic [7:0] op, output int aw, output int dw);
    aw = 1; dw = 1;
    case (op)
      8'h3B:               dw = 2;
      8'hBB, 8'h92:        begin aw = 2; dw = 2; end
      8'h6B, 8'h32:        dw = 4;
      8'hEB, 8'hE7, 8'h94: begin aw = 4; dw = 4; end
      default: ;
    endcase
  endfunction

  function automatic logic [1:0] wcode(input int w);
    return (w == 4) ? 2'd2 : (w == 2) ? 2'd1 : 2'd0;
  endfunction

  // receive side of the model
  always @(posedge sclk) begin
    int w;
    e_opv = 0;
    e_rxv = 0;
    if (cs_ni || !rst_ni) begin
      m_bits = 0; m_nbytes = 0; m_aw = 1; m_dw = 1; m_dead = 0; m_acc = 0;
    end else if (!m_dead) begin
      w = (m_nbytes == 0) ? 1 : (m_nbytes <= ADDR) ? m_aw : m_dw;
      for (int k = w - 1; k >= 0; k--) m_acc = {m_acc[6:0], io_i[k]};
      m_bits += w;
      if (m_bits == 8) begin
        m_bits = 0;
        if (m_nbytes == 0) begin
          e_opv = 1;
          e_op = m_acc;
          dec(m_acc, m_aw, m_dw);
          if (m_dw == 4 && !qe_i) m_dead = 1;
        end else begin
          e_rxv = 1;
          e_rxb = m_acc;
          e_rxa = (m_nbytes <= ADDR);
        end
        m_nbytes++;
      end
    end
    if (cs_ni || !rst_ni || m_dead) e_lanes = 2'd0;
    else e_lanes = wcode((m_nbytes == 0) ? 1 : (m_nbytes <= ADDR) ? m_aw : m_dw);
  end

  always @(posedge sclk) begin
    #1;
    tx_byte_i = 8'h5A + 8'(m_nbytes * 19);
  end

  // transmit side of the model
  always @(negedge sclk) begin
    e_oe = 4'h0;
    e_io = 4'h0;
    if (!cs_ni && rst_ni && !m_dead && m_nbytes > ADDR && tx_en_i) begin
      if (m_bits == 0) m_tx = tx_byte_i;
      if (m_dw == 1) begin
        e_io[1] = m_tx[7];
        e_oe = 4'b0010;
      end else begin
        for (int k = 0; k < m_dw; k++) e_io[k] = m_tx[8 - m_dw + k];
        e_oe = 4'((1 << m_dw) - 1);
      end
      m_tx = m_tx << m_dw;
    end
  end

  always @(posedge sclk) begin
    #2;
    if (cs_ni || !rst_ni) begin
      chk(io_oe_o == 0 && !op_valid_o && !rx_valid_o && !invalid_o && lanes_o == 0,
          "R10", "idle outputs", {io_oe_o, 1'b0, op_valid_o, rx_valid_o, invalid_o}, 0);
    end else begin
      chk(op_valid_o == e_opv, "R2", "op_valid", op_valid_o, e_opv);
      if (e_opv) chk(opcode_o == e_op, "R2", "opcode", opcode_o, e_op);
      chk(rx_valid_o == e_rxv, "R11", "rx_valid", rx_valid_o, e_rxv);
      if (e_rxv) begin
        chk(rx_byte_o == e_rxb, "R9", "rx_byte", rx_byte_o, e_rxb);
        chk(rx_addr_o == e_rxa, "R11", "rx_addr", rx_addr_o, e_rxa);
      end
      chk(invalid_o == m_dead, "R8", "invalid", invalid_o, m_dead);
      chk(lanes_o == e_lanes, "R4", "lanes", lanes_o, e_lanes);
    end
    if (rx_valid_o) got.push_back(rx_byte_o);
  end

  always @(negedge sclk) begin
    #2;
    chk(io_oe_o == e_oe, "R12", "io_oe", io_oe_o, e_oe);
    for (int k = 0; k < 4; k++)
      if (e_oe[k]) chk(io_o[k] == e_io[k], "R9", "io_o lane", io_o, e_io);
  end

  task automatic beat(input logic [7:0] b, input int w, input int j);
    if (!first_beat) begin
      @(negedge sclk);
      #1;
    end
    first_beat = 0;
    for (int k = 0; k < 4; k++) begin
      if (k < w) io_i[k] = b[7 - j * w - (w - 1 - k)];
      else io_i[k] = 1'($urandom);
    end
    @(posedge sclk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int w);
    for (int j = 0; j < 8 / w; j++) beat(b, w, j);
  endtask

  task automatic start(input bit m3);
    got.delete();
    if (m3) begin
      @(posedge sclk); #1 cs_ni = 0;
      first_beat = 0;
    end else begin
      @(negedge sclk); #1 cs_ni = 0;
      first_beat = 1;
    end
  endtask

  task automatic xfer(input string tag, input logic [7:0] op, input bit qe, input bit m3,
                      input bit ten, input int ndata, input int aw, input int dw, input bit dead);
    logic [7:0] sent[$];
    cur_tag = tag;
    qe_i = qe;
    tx_en_i = ten;
    start(m3);
    send_byte(op, 1);
    for (int i = 0; i < ADDR; i++) begin
      sent.push_back(8'($urandom));
      send_byte(sent[i], aw);
    end
    for (int i = 0; i < ndata; i++) begin
      sent.push_back(8'($urandom));
      send_byte(sent[ADDR + i], dw);
    end
    #3 cs_ni = 1;
    tx_en_i = 0;
    repeat (3) @(posedge sclk);
    if (dead) begin
      chk(got.size() == 0, tag, "bytes from rejected command", got.size(), 0);
    end else begin
      chk(got.size() == sent.size(), tag, "byte count", got.size(), sent.size());
      for (int i = 0; i < sent.size() && i < got.size(); i++)
        chk(got[i] == sent[i], tag, "byte value", got[i], sent[i]);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge sclk);
    #3;
    chk(io_oe_o == 0 && lanes_o == 0 && !invalid_o, "R10", "reset state", io_oe_o, 0);
    rst_ni = 1;
    repeat (2) @(posedge sclk);
    xfer("R3", 8'h03, 0, 0, 1, 3, 1, 1, 0);
    xfer("R1", 8'h3B, 0, 1, 1, 3, 1, 2, 0);
    xfer("R5", 8'h3B, 0, 0, 0, 2, 1, 2, 0);
    xfer("R4", 8'hBB, 0, 0, 0, 3, 2, 2, 0);
    xfer("R4", 8'h92, 0, 1, 1, 2, 2, 2, 0);
    xfer("R6", 8'hEB, 1, 0, 1, 4, 4, 4, 0);
    xfer("R6", 8'hE7, 1, 1, 0, 2, 4, 4, 0);
    xfer("R6", 8'h94, 1, 0, 1, 2, 4, 4, 0);
    xfer("R7", 8'h6B, 1, 0, 1, 3, 1, 4, 0);
    xfer("R7", 8'h32, 1, 1, 0, 3, 1, 4, 0);
    xfer("R8", 8'hEB, 0, 0, 1, 2, 4, 4, 1);
    xfer("R8", 8'h32, 0, 1, 1, 2, 1, 4, 1);
    // abort in the middle of an address byte
    cur_tag = "R10";
    qe_i = 1;
    tx_en_i = 1;
    start(0);
    send_byte(8'hEB, 1);
    beat(8'hC3, 4, 0);
    #1 cs_ni = 1;
    #1;
    chk(io_oe_o == 0 && !invalid_o && lanes_o == 0 && !rx_valid_o, "R10",
        "state after abort", {io_oe_o, 2'b00, lanes_o}, 0);
    tx_en_i = 0;
    repeat (2) @(posedge sclk);
    xfer("R10", 8'hBB, 0, 0, 1, 2, 2, 2, 0);
    xfer("R11", 8'h0B, 0, 1, 0, 2, 1, 1, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule